// File: doc/BRIEF.md
# Function-Coded 32-bit Integer ALU

This block is a purely combinational integer datapath unit. Two 32-bit operands and a 4-bit operation selector go in. A 32-bit result and three comparison flags come out. The selector picks one of eight operations: wrap-around addition and subtraction, three kinds of shift, bitwise exclusive-or, bitwise not-or, and an equality operation that reports through a flag and leaves the result at zero.

The equality, signed-less-than and unsigned-less-than flags are outputs of their own. They are computed from the operands on every evaluation, whatever the selector holds, so a branch unit can use them alongside any arithmetic result. Shift distances come from the five least significant bits of the second operand. Selector values that map to no operation give a zero result.

Top module: `int_alu32`

## Requirements
- R1: Selector value 0 gives `op_a + op_b` modulo 2^32.
- R2: Selector value 1 gives `op_a - op_b` modulo 2^32 (0x00132050 - 0xd6620040 = 0x29b12010).
- R3: Selector value 2 shifts `op_a` left and fills with zeros. The distance is `op_b[4:0]`, and the upper bits of `op_b` are ignored.
- R4: Selector value 9 shifts `op_a` right and fills with zeros. The distance is `op_b[4:0]`.
- R5: Selector value 10 shifts `op_a` right and fills with copies of bit 31. The distance is `op_b[4:0]`, so 0xffffff01 shifts by 1. 0x80808080 shifted by 8 gives 0xff808080, and shifted by 31 gives 0xffffffff.
- R6: Selector value 7 gives the bitwise exclusive-or of the operands.
- R7: Selector value 8 gives the bitwise inverse of the operands' OR, so two zero operands give 0xffffffff.
- R8: Selector value 14 drives the result to 0.
- R9: `flag_eq` is 1 exactly when the operands are equal, for every selector value.
- R10: `flag_lt` is 1 exactly when `op_a` is less than `op_b` as two's-complement numbers, for every selector value.
- R11: `flag_ltu` is 1 exactly when `op_a` is less than `op_b` as unsigned numbers, for every selector value.
- R12: Selector values 3, 4, 5, 6, 11, 12, 13 and 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand; also the value that is shifted |
| op_b | input | 32 | Second operand; bits [4:0] give the shift distance |
| fn_code | input | 4 | Operation selector |
| result | output | 32 | Result of the selected operation |
| flag_eq | output | 1 | Operands are equal |
| flag_lt | output | 1 | op_a < op_b, signed |
| flag_ltu | output | 1 | op_a < op_b, unsigned |

## Verification
No register lies between any input and any output. The result and all three flags are therefore due in the same cycle that the operands and selector change. The bench applies each vector just after a rising clock edge and compares every output at the following falling edge, half a period later, once the logic has settled. Expected values come from a behavioural model written with the language's own operators, and from directed literal values for the shift and wrap corners.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
   localparam int FN_W = 4;

   typedef enum logic [FN_W-1:0] {
      ALU_ADD = 4'd0,
      ALU_SUB = 4'd1,
      ALU_SLL = 4'd2,
      ALU_XOR = 4'd7,
      ALU_NOR = 4'd8,
      ALU_SRL = 4'd9,
      ALU_SRA = 4'd10,
      ALU_EQ  = 4'd14
   } alu_fn_e;
endpackage

// File: rtl/int_alu_arith.sv
// Adder, subtractor and comparison flags derived from the subtractor.
module int_alu_arith #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] sum,
   output logic [WIDTH-1:0] diff,
   output logic             is_eq,
   output logic             is_lt,
   output logic             is_ltu
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH:0] sub_ext;

   always_comb begin
      sum     = a + b;
      sub_ext = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
      diff    = sub_ext[MSB:0];
      // no carry out of a + ~b + 1 means a borrow, i.e. a < b unsigned
      is_ltu  = ~sub_ext[WIDTH];
      is_lt   = (a[MSB] != b[MSB]) ? a[MSB] : diff[MSB];
      is_eq   = (diff == '0);
   end
endmodule

// File: rtl/int_alu_shift.sv
// Shift unit: left logical, right logical and right arithmetic.
module int_alu_shift #(
   parameter int WIDTH  = 32,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] val,
   input  logic [SHW-1:0]   amt,
   input  logic             left,
   input  logic             arith,
   output logic [WIDTH-1:0] res
);
   if (BARREL) begin : g_barrel
      logic [WIDTH-1:0] src, src_rev, out_rev;
      logic [WIDTH-1:0] stage [SHW+1];
      logic             fill;

      for (genvar i = 0; i < WIDTH; i++) begin : g_rev
         assign src_rev[i] = val[WIDTH-1-i];
         assign out_rev[i] = stage[SHW][WIDTH-1-i];
      end

      // a left shift runs as a right shift on the bit-reversed value
      assign src      = left ? src_rev : val;
      assign fill     = arith & ~left & val[WIDTH-1];
      assign stage[0] = src;

      for (genvar s = 0; s < SHW; s++) begin : g_stage
         localparam int STEP = 1 << s;
         assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][WIDTH-1:STEP]}
                                    : stage[s];
      end

      assign res = left ? out_rev : stage[SHW];
   end else begin : g_operator
      always_comb begin
         if (left)       res = val << amt;
         else if (arith) res = $unsigned($signed(val) >>> amt);
         else            res = val >> amt;
      end
   end
endmodule

// File: rtl/int_alu_logic.sv
// Bitwise unit.
module int_alu_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] x_xor,
   output logic [WIDTH-1:0] x_nor
);
   assign x_xor = a ^ b;
   assign x_nor = ~(a | b);
endmodule

// File: rtl/int_alu32.sv
module int_alu32 #(
   parameter int WIDTH  = 32,
   parameter bit BARREL = 1'b1
) (
   input  logic [31:0] op_a,
   input  logic [31:0] op_b,
   input  logic [3:0]  fn_code,
   output logic [31:0] result,
   output logic        flag_eq,
   output logic        flag_lt,
   output logic        flag_ltu
);
   import int_alu_pkg::*;

   localparam int SHW = $clog2(WIDTH);

   if (WIDTH != 32) begin : g_bad_width
      $error("int_alu32: WIDTH must be 32 to match the port list");
   end
   if ((1 << SHW) != WIDTH) begin : g_bad_pow2
      $error("int_alu32: WIDTH must be a power of two");
   end

   logic [WIDTH-1:0] sum_w, diff_w, shf_w, xor_w, nor_w;
   logic             sh_left, sh_arith;

   int_alu_arith #(.WIDTH(WIDTH)) arith_i (
      .a(op_a), .b(op_b), .sum(sum_w), .diff(diff_w),
      .is_eq(flag_eq), .is_lt(flag_lt), .is_ltu(flag_ltu)
   );

   assign sh_left  = (fn_code == ALU_SLL);
   assign sh_arith = (fn_code == ALU_SRA);

   int_alu_shift #(.WIDTH(WIDTH), .BARREL(BARREL)) shift_i (
      .val(op_a), .amt(op_b[SHW-1:0]), .left(sh_left), .arith(sh_arith),
      .res(shf_w)
   );

   int_alu_logic #(.WIDTH(WIDTH)) logic_i (
      .a(op_a), .b(op_b), .x_xor(xor_w), .x_nor(nor_w)
   );

   always_comb begin
      unique case (fn_code)
         ALU_ADD:                   result = sum_w;
         ALU_SUB:                   result = diff_w;
         ALU_SLL, ALU_SRL, ALU_SRA: result = shf_w;
         ALU_XOR:                   result = xor_w;
         ALU_NOR:                   result = nor_w;
         default:                   result = '0;
      endcase
   end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [3:0]       fn_code,
   input logic [WIDTH-1:0] result,
   input logic             flag_eq,
   input logic             flag_lt,
   input logic             flag_ltu
);
   always_comb begin
      if (fn_code == 4'd0)
         a_r1_add_inverse: assert (result - op_b == op_a);
      if (fn_code == 4'd1)
         a_r2_sub_inverse: assert (result + op_b == op_a);
      if (fn_code == 4'd8)
         a_r7_nor_disjoint: assert (((result & (op_a | op_b)) == '0) &&
                                    ((result | op_a | op_b) == '1));
      if (fn_code == 4'd14)
         a_r8_eq_zero_result: assert (result == '0);
      if (flag_eq)
         a_r9_eq_excludes_lt: assert (!flag_lt && !flag_ltu);
      if (op_a[WIDTH-1] == op_b[WIDTH-1])
         a_r11_same_sign_agree: assert (flag_lt == flag_ltu);
      if (!(fn_code inside {4'd0, 4'd1, 4'd2, 4'd7, 4'd8, 4'd9, 4'd10}))
         a_r12_unused_zero: assert (result == '0);
   end
endmodule

bind int_alu32 int_alu_chk #(.WIDTH(WIDTH)) chk_i (
   .op_a(op_a), .op_b(op_b), .fn_code(fn_code), .result(result),
   .flag_eq(flag_eq), .flag_lt(flag_lt), .flag_ltu(flag_ltu)
);

// File: tb/int_alu32_tb_top.sv
module int_alu32_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic [3:0]  fn_code = '0;
   logic [31:0] result;
   logic        flag_eq, flag_lt, flag_ltu;
   int          n_vec = 0, n_bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   int_alu32 dut_i (
      .op_a(op_a), .op_b(op_b), .fn_code(fn_code), .result(result),
      .flag_eq(flag_eq), .flag_lt(flag_lt), .flag_ltu(flag_ltu)
   );

   function automatic logic [31:0] ref_res(logic [31:0] a, logic [31:0] b, logic [3:0] f);
      int sh = int'(b[4:0]);
      case (f)
         4'd0:  return a + b;
         4'd1:  return a - b;
         4'd2:  return a << sh;
         4'd7:  return a ^ b;
         4'd8:  return ~(a | b);
         4'd9:  return a >> sh;
         4'd10: return $unsigned($signed(a) >>> sh);
         default: return 32'h0;
      endcase
   endfunction

   // apply one vector; exp is the expected result; flags come from R9, R10, R11
   task automatic check_vec(logic [31:0] a, logic [31:0] b, logic [3:0] f,
                            logic [31:0] exp, string req);
      logic e_eq, e_lt, e_ltu;
      @(posedge clk); #1;
      op_a = a; op_b = b; fn_code = f;
      @(negedge clk);
      e_eq  = (a == b);
      e_lt  = ($signed(a) < $signed(b));
      e_ltu = (a < b);
      n_vec++;
      if (result !== exp) begin
         n_bad++;
         $display("FAIL %s: fn=%0d a=%h b=%h result actual %h expected %h", req, f, a, b, result, exp);
      end else if (flag_eq !== e_eq || flag_lt !== e_lt || flag_ltu !== e_ltu) begin
         n_bad++;
         $display("FAIL R9/R10/R11 flags: a=%h b=%h actual eq%b lt%b ltu%b expected eq%b lt%b ltu%b",
                  a, b, flag_eq, flag_lt, flag_ltu, e_eq, e_lt, e_ltu);
      end
   endtask

   task automatic t_reset_state;
      check_vec(32'h0, 32'h0, 4'd0, 32'h0, "R1 idle");
   endtask

   task automatic t_add;
      check_vec(32'h0ffaa660, 32'h00012304, 4'd0, 32'h0ffbc964, "R1");
      check_vec(32'hfeeeeaa3, 32'hf4650000, 4'd0, 32'hf353eaa3, "R1 wrap");
      check_vec(32'hffffffff, 32'h00000001, 4'd0, 32'h0, "R1 wrap");
   endtask

   task automatic t_sub;
      check_vec(32'h00132050, 32'hd6620040, 4'd1, 32'h29b12010, "R2");
      check_vec(32'h0, 32'h1, 4'd1, 32'hffffffff, "R2 wrap");
   endtask

   task automatic t_shift_left;
      check_vec(32'h05050505, 32'h00000002, 4'd2, 32'h14141414, "R3");
      check_vec(32'h50505050, 32'hffffff0f, 4'd2, 32'h28280000, "R3 upper ignored");
      check_vec(32'h50505050, 32'h0000001f, 4'd2, 32'h0, "R3");
   endtask

   task automatic t_shift_right_log;
      check_vec(32'h50505050, 32'h0000000f, 4'd9, 32'h0000a0a0, "R4");
      check_vec(32'h80000000, 32'h0000003f, 4'd9, 32'h00000001, "R4 upper ignored");
   endtask

   task automatic t_shift_right_arith;
      check_vec(32'h05050505, 32'hffffff01, 4'd10, 32'h02828282, "R5");
      check_vec(32'h80808080, 32'h00000008, 4'd10, 32'hff808080, "R5");
      check_vec(32'h80808080, 32'h0000001f, 4'd10, 32'hffffffff, "R5");
      check_vec(32'h80808080, 32'h00000000, 4'd10, 32'h80808080, "R5 zero");
   endtask

   task automatic t_bitwise;
      check_vec(32'h0ffaa660, 32'h00012304, 4'd7, 32'h0ffb8564, "R6");
      check_vec(32'h0, 32'h0, 4'd8, 32'hffffffff, "R7");
      check_vec(32'hfff0a440, 32'h00004450, 4'd8, 32'h000f1baf, "R7");
   endtask

   task automatic t_equality;
      check_vec(32'h1234abcd, 32'h1234abcd, 4'd14, 32'h0, "R8 R9");
      check_vec(32'h1234abcd, 32'h1234abcc, 4'd14, 32'h0, "R8 R9");
   endtask

   task automatic t_compare;
      // sign differs: signed and unsigned verdicts disagree (R10, R11)
      check_vec(32'h80000000, 32'h00000001, 4'd7, 32'h80000001, "R10 R11");
      check_vec(32'h00000001, 32'hffffffff, 4'd0, 32'h0, "R10 R11");
      check_vec(32'h7fffffff, 32'h7ffffffe, 4'd1, 32'h1, "R10 R11");
   endtask

   task automatic t_unused;
      foreach (dut_unused[k])
         check_vec(32'hdeadbeef, 32'h00000003, dut_unused[k], 32'h0, "R12");
   endtask
   logic [3:0] dut_unused [8] = '{4'd3, 4'd4, 4'd5, 4'd6, 4'd11, 4'd12, 4'd13, 4'd15};

   task automatic t_sweep;
      logic [31:0] a = 32'h1badf00d, b = 32'h00c0ffee;
      logic [3:0]  codes [8] = '{4'd0, 4'd1, 4'd2, 4'd7, 4'd8, 4'd9, 4'd10, 4'd14};
      for (int i = 0; i < 64; i++) begin
         a = {a[30:0], a[31] ^ a[21] ^ a[1] ^ a[0]};
         b = {b[30:0], b[31] ^ b[21] ^ b[1] ^ b[0]} ^ a;
         check_vec(a, b, codes[i % 8], ref_res(a, b, codes[i % 8]), "R1..sweep R6 R7");
      end
   endtask

   initial begin
      #5000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_add();
      t_sub();
      t_shift_left();
      t_shift_right_log();
      t_shift_right_arith();
      t_bitwise();
      t_equality();
      t_compare();
      t_unused();
      t_sweep();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule